// File: doc/BRIEF.md
# Microstepping Stepper Indexer

This block is the digital sequencer for a two-phase bipolar stepper motor. It holds a 7-bit position pointer into one electrical cycle of 128 fine positions, about 2.8 electrical degrees apart. It moves the pointer on each accepted rising edge of an asynchronous step input. It turns the pointer into two signed 8-bit current setpoints: winding A follows the cosine of the electrical angle and winding B follows the sine. The analog regulator that follows uses these setpoints as its targets.

Six resolutions share the single fine table. Coarser modes move the pointer by a larger stride, and full-step mode snaps onto the 45°+90°k grid. Four conditions gate the step input: the active-low reset, the active-low enable, the active-low sleep with a wake-up lockout counter, and a latched overcurrent fault. The fault latches only after the overcurrent input has stayed asserted beyond a persistence window. The reset input is also the block's asynchronous reset.

Top module: `stepper_indexer`

## Requirements
- R1: While resetN is low and after it returns high, the pointer is at home position 16 (45°), so both setpoints read +90, faultN is 1 and bridgeOn is 0 while resetN is low.
- R2: For pointer p, the angle is θ = p·360°/128, coilA = round(127·cos θ) and coilB = round(127·sin θ), both two's complement 8-bit. For example, p=112 gives +90/−90 and p=127 gives +127/−6.
- R3: stepIn passes through two synchronizer flops. A rising edge first sampled high at clock edge k moves the pointer at edge k+2. Each rising edge gives one move, and holding stepIn high gives no further moves.
- R4: dirIn=1 increments the pointer and dirIn=0 decrements it, wrapping modulo 128 both ways.
- R5: modeSel sets the stride in fine units: 1→16 (half), 2→8 (quarter), 3→4 (eighth), 4→2 (sixteenth), 5, 6 and 7→1 (fine).
- R6: modeSel=0 (full step) moves the pointer to the next position p≡16 (mod 32) in the chosen direction, snapping from any off-grid position.
- R7: When enableN is high, bridgeOn is 0 and step edges are ignored. When enableN is low, sleepN is high, resetN is high and there is no fault, bridgeOn is 1.
- R8: When sleepN is low, bridgeOn is 0, step edges are ignored, and ocpIn is ignored (its persistence count is cleared).
- R9: Step edges are ignored for WAKE_CYCLES clock cycles after sleepN rises, and for the same span after resetN is released.
- R10: ocpIn sampled high on more than OCP_CYCLES consecutive edges (with sleepN high) latches a fault. faultN goes low, bridgeOn goes low and steps are ignored. A burst of OCP_CYCLES samples or fewer has no effect.
- R11: A latched fault persists through enable and sleep changes and clears only when resetN is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| resetN | input | 1 | Active-low reset, returns pointer home and clears fault |
| enableN | input | 1 | Active-low bridge and indexer enable |
| sleepN | input | 1 | Active-low sleep request |
| stepIn | input | 1 | Asynchronous step request, rising edge active |
| dirIn | input | 1 | Direction: 1 forward, 0 reverse |
| modeSel | input | 3 | Resolution select (see R5, R6) |
| ocpIn | input | 1 | Overcurrent condition from the power stage |
| coilA | output | 8 | Signed winding A setpoint (cosine) |
| coilB | output | 8 | Signed winding B setpoint (sine) |
| bridgeOn | output | 1 | Power bridge enable |
| faultN | output | 1 | Active-low latched overcurrent fault |

## Verification
The stepping function is tried in several ways. A fine forward run of more than one full cycle exposes wrap errors and any table or quadrant-fold entry that is wrong. Short forward and reverse bursts in each coarse mode tell one stride from another. Full-step moves that start from a position off the grid separate snapping from plain stride addition. A step held high for many cycles separates edge detection from level sensing. Step pulses issued while disabled, asleep, inside the wake lockout and while faulted each check a separate gate. Overcurrent bursts of exactly the window length and just beyond it locate the latch threshold.

// File: rtl/indexer_pkg.sv
package indexer_pkg;
  localparam int POS_W = 7;              // 128 fine positions per electrical cycle
  localparam int QTR_W = POS_W - 2;      // bits inside one quadrant
  localparam int AMP_W = 8;              // signed setpoint width
  localparam logic [POS_W-1:0] HOME_POS = 7'd16;  // 45 degrees

  localparam logic [2:0] MODE_FULL      = 3'd0;
  localparam logic [2:0] MODE_HALF      = 3'd1;
  localparam logic [2:0] MODE_QUARTER   = 3'd2;
  localparam logic [2:0] MODE_EIGHTH    = 3'd3;
  localparam logic [2:0] MODE_SIXTEENTH = 3'd4;

  typedef struct packed {
    logic move;   // accepted step this cycle
    logic up;     // direction of the move
  } idx_strobe_t;
endpackage

// File: rtl/quarter_sine_lut.sv
module quarter_sine_lut
  import indexer_pkg::*;
(
  input  logic [POS_W-1:0]        angle,
  output logic signed [AMP_W-1:0] value
);
  function automatic logic [AMP_W-1:0] quarterMag(input logic [QTR_W:0] k);
    case (k)
      6'd0:  quarterMag = 8'd0;
      6'd1:  quarterMag = 8'd6;
      6'd2:  quarterMag = 8'd12;
      6'd3:  quarterMag = 8'd19;
      6'd4:  quarterMag = 8'd25;
      6'd5:  quarterMag = 8'd31;
      6'd6:  quarterMag = 8'd37;
      6'd7:  quarterMag = 8'd43;
      6'd8:  quarterMag = 8'd49;
      6'd9:  quarterMag = 8'd54;
      6'd10: quarterMag = 8'd60;
      6'd11: quarterMag = 8'd65;
      6'd12: quarterMag = 8'd71;
      6'd13: quarterMag = 8'd76;
      6'd14: quarterMag = 8'd81;
      6'd15: quarterMag = 8'd85;
      6'd16: quarterMag = 8'd90;
      6'd17: quarterMag = 8'd94;
      6'd18: quarterMag = 8'd98;
      6'd19: quarterMag = 8'd102;
      6'd20: quarterMag = 8'd106;
      6'd21: quarterMag = 8'd109;
      6'd22: quarterMag = 8'd112;
      6'd23: quarterMag = 8'd115;
      6'd24: quarterMag = 8'd117;
      6'd25: quarterMag = 8'd120;
      6'd26: quarterMag = 8'd122;
      6'd27: quarterMag = 8'd123;
      6'd28: quarterMag = 8'd125;
      6'd29: quarterMag = 8'd126;
      6'd30: quarterMag = 8'd126;
      default: quarterMag = 8'd127;
    endcase
  endfunction

  logic [QTR_W:0]          fold;
  logic [AMP_W-1:0]        mag;
  logic signed [AMP_W-1:0] smag;

  always_comb begin
    // odd quadrants run the quarter wave backwards
    if (angle[QTR_W])
      fold = {1'b1, {QTR_W{1'b0}}} - {1'b0, angle[QTR_W-1:0]};
    else
      fold = {1'b0, angle[QTR_W-1:0]};
    mag   = quarterMag(fold);
    smag  = $signed(mag);
    // lower half-cycle is negative
    value = angle[POS_W-1] ? -smag : smag;
  end
endmodule

// File: rtl/indexer_ctrl.sv
module indexer_ctrl
  import indexer_pkg::*;
#(
  parameter int WAKE_CYCLES = 200000,
  parameter int OCP_CYCLES  = 600
) (
  input  logic        clk,
  input  logic        resetN,
  input  logic        enableN,
  input  logic        sleepN,
  input  logic        stepIn,
  input  logic        dirIn,
  input  logic        ocpIn,
  output idx_strobe_t stb,
  output logic        bridgeOn,
  output logic        faultN
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam int OCP_W  = $clog2(OCP_CYCLES + 1);
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES);
  localparam logic [OCP_W-1:0]  OCP_LIMIT = OCP_W'(OCP_CYCLES);

  logic [2:0]        stepPipe;   // [0],[1] synchronizer, [2] edge history
  logic              stepRise;
  logic [WAKE_W-1:0] wakeCnt;
  logic              lockout;
  logic [OCP_W-1:0]  ocpCnt;
  logic              faultLatched;
  logic              stepGate;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) stepPipe <= '0;
    else         stepPipe <= {stepPipe[1:0], stepIn};
  end

  assign stepRise = stepPipe[1] & ~stepPipe[2];

  // wake lockout: reloaded while asleep or in reset, drains once awake
  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN)             wakeCnt <= WAKE_LOAD;
    else if (!sleepN)        wakeCnt <= WAKE_LOAD;
    else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
  end

  assign lockout = (wakeCnt != '0);

  // overcurrent persistence window and sticky fault
  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      ocpCnt       <= '0;
      faultLatched <= 1'b0;
    end else if (!sleepN) begin
      ocpCnt <= '0;
    end else if (ocpIn) begin
      if (ocpCnt == OCP_LIMIT) faultLatched <= 1'b1;
      else                     ocpCnt <= ocpCnt + 1'b1;
    end else begin
      ocpCnt <= '0;
    end
  end

  assign stepGate = ~enableN & sleepN & ~lockout & ~faultLatched;

  always_comb begin
    stb.move = stepRise & stepGate;
    stb.up   = dirIn;
  end

  assign bridgeOn = resetN & ~enableN & sleepN & ~faultLatched;
  assign faultN   = ~faultLatched;

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!resetN)
    !faultN |=> !faultN);

  assert_short_burst_no_fault_R10: assert property (@(posedge clk) disable iff (!resetN)
    (faultN && !ocpIn) |=> faultN);

  assert_one_move_per_edge_R3: assert property (@(posedge clk) disable iff (!resetN)
    stb.move |=> !stb.move);
endmodule

// File: rtl/indexer_datapath.sv
module indexer_datapath
  import indexer_pkg::*;
(
  input  logic                    clk,
  input  logic                    resetN,
  input  idx_strobe_t             stb,
  input  logic [2:0]              modeSel,
  output logic [POS_W-1:0]        posIdx,
  output logic signed [AMP_W-1:0] coilA,
  output logic signed [AMP_W-1:0] coilB
);
  logic [2:0]       strideShift;
  logic [POS_W-1:0] stride;
  logic [POS_W-1:0] rel;
  logic [1:0]       quad;
  logic [POS_W-1:0] fullNext;
  logic [POS_W-1:0] posNext;

  always_comb begin
    case (modeSel)
      MODE_HALF:      strideShift = 3'd4;
      MODE_QUARTER:   strideShift = 3'd3;
      MODE_EIGHTH:    strideShift = 3'd2;
      MODE_SIXTEENTH: strideShift = 3'd1;
      default:        strideShift = 3'd0;
    endcase
    stride = {{(POS_W-1){1'b0}}, 1'b1} << strideShift;

    // full step: work relative to the 45 degree grid
    rel = posIdx - HOME_POS;
    if (stb.up)
      quad = rel[POS_W-1:QTR_W] + 2'd1;
    else
      quad = rel[POS_W-1:QTR_W] - {1'b0, (rel[QTR_W-1:0] == '0)};
    fullNext = {quad, {QTR_W{1'b0}}} + HOME_POS;

    if (modeSel == MODE_FULL) posNext = fullNext;
    else if (stb.up)          posNext = posIdx + stride;
    else                      posNext = posIdx - stride;
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN)       posIdx <= HOME_POS;
    else if (stb.move) posIdx <= posNext;
  end

  // phase 0 (A) leads by a quarter cycle: cosine; phase 1 (B): sine
  logic signed [AMP_W-1:0] amp [2];
  for (genvar g = 0; g < 2; g++) begin : g_phase
    localparam logic [POS_W-1:0] OFFS = (g == 0) ? {2'b01, {QTR_W{1'b0}}} : '0;
    quarter_sine_lut u_lut (
      .angle (posIdx + OFFS),
      .value (amp[g])
    );
  end

  assign coilA = amp[0];
  assign coilB = amp[1];

  assert_fine_stride_R5: assert property (@(posedge clk) disable iff (!resetN)
    (stb.move && stb.up && modeSel >= 3'd5) |=> posIdx == $past(posIdx) + 7'd1);

  assert_full_snap_R6: assert property (@(posedge clk) disable iff (!resetN)
    (stb.move && modeSel == MODE_FULL) |=> posIdx[QTR_W-1:0] == 5'd16);

  assert_hold_without_move_R3: assert property (@(posedge clk) disable iff (!resetN)
    !stb.move |=> $stable(posIdx));
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import indexer_pkg::*;
#(
  parameter int WAKE_CYCLES = 200000,
  parameter int OCP_CYCLES  = 600
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              enableN,
  input  logic              sleepN,
  input  logic              stepIn,
  input  logic              dirIn,
  input  logic [2:0]        modeSel,
  input  logic              ocpIn,
  output logic signed [7:0] coilA,
  output logic signed [7:0] coilB,
  output logic              bridgeOn,
  output logic              faultN
);
  idx_strobe_t      stb;
  logic [POS_W-1:0] posIdx;

  indexer_ctrl #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .OCP_CYCLES  (OCP_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .resetN   (resetN),
    .enableN  (enableN),
    .sleepN   (sleepN),
    .stepIn   (stepIn),
    .dirIn    (dirIn),
    .ocpIn    (ocpIn),
    .stb      (stb),
    .bridgeOn (bridgeOn),
    .faultN   (faultN)
  );

  indexer_datapath u_dp (
    .clk     (clk),
    .resetN  (resetN),
    .stb     (stb),
    .modeSel (modeSel),
    .posIdx  (posIdx),
    .coilA   (coilA),
    .coilB   (coilB)
  );

  assert_sleep_freeze_R8: assert property (@(posedge clk) disable iff (!resetN)
    !sleepN |=> $stable(posIdx));

  assert_wake_lockout_R9: assert property (@(posedge clk) disable iff (!resetN)
    $rose(sleepN) |=> $stable(posIdx));

  assert_disable_freeze_R7: assert property (@(posedge clk) disable iff (!resetN)
    enableN |=> $stable(posIdx));

  assert_fault_freeze_R10: assert property (@(posedge clk) disable iff (!resetN)
    !faultN |=> $stable(posIdx));
endmodule

// File: tb/tb_stepper_indexer.sv
`timescale 1ns/1ps
module tb_stepper_indexer;
  localparam int WAKE = 40;
  localparam int OCP  = 10;

  logic clk = 1'b0;
  logic resetN = 1'b0;
  logic enableN = 1'b1;
  logic sleepN = 1'b1;
  logic stepIn = 1'b0;
  logic dirIn = 1'b1;
  logic [2:0] modeSel = 3'd0;
  logic ocpIn = 1'b0;
  logic signed [7:0] coilA, coilB;
  logic bridgeOn, faultN;

  always #2.5 clk = ~clk;

  stepper_indexer #(.WAKE_CYCLES(WAKE), .OCP_CYCLES(OCP)) dut (
    .clk(clk), .resetN(resetN), .enableN(enableN), .sleepN(sleepN),
    .stepIn(stepIn), .dirIn(dirIn), .modeSel(modeSel), .ocpIn(ocpIn),
    .coilA(coilA), .coilB(coilB), .bridgeOn(bridgeOn), .faultN(faultN)
  );

  int nChecks = 0;
  int nFails = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string curTag = "R1";

  // behavioural reference state
  int mS1 = 0, mS2 = 0, mS3 = 0;
  int mPos = 16;
  int mWake = WAKE;
  int mOcp = 0;
  bit mFault = 1'b0;

  function automatic int rnd(real v);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  function automatic int expCos(int p);
    return rnd(127.0 * $cos(2.0 * 3.14159265358979 * p / 128.0));
  endfunction

  function automatic int expSin(int p);
    return rnd(127.0 * $sin(2.0 * 3.14159265358979 * p / 128.0));
  endfunction

  function automatic int nextPos(int p, int m, bit up);
    int q;
    int st;
    if (m == 0) begin
      q = (p - 16 + 128) % 128;
      if (up)            return ((q / 32 + 1) % 4) * 32 + 16;
      else if (q % 32)   return (q / 32) * 32 + 16;
      else               return ((q / 32 + 3) % 4) * 32 + 16;
    end
    case (m)
      1: st = 16;
      2: st = 8;
      3: st = 4;
      4: st = 2;
      default: st = 1;
    endcase
    return up ? (p + st) % 128 : (p - st + 128) % 128;
  endfunction

  always @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      mS1 = 0; mS2 = 0; mS3 = 0; mPos = 16; mWake = WAKE; mOcp = 0; mFault = 1'b0;
    end else begin
      if (mS2 == 1 && mS3 == 0 && !enableN && sleepN && mWake == 0 && !mFault)
        mPos = nextPos(mPos, int'(modeSel), dirIn);
      mS3 = mS2; mS2 = mS1; mS1 = int'(stepIn);
      if (!sleepN) mWake = WAKE;
      else if (mWake > 0) mWake--;
      if (!sleepN) mOcp = 0;
      else if (ocpIn) begin
        if (mOcp == OCP) mFault = 1'b1;
        else mOcp++;
      end else mOcp = 0;
    end
  end

  task automatic check(int act, int exp, string tag, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !done) begin
      check(int'(coilA), expCos(mPos), curTag, "coilA");
      check(int'(coilB), expSin(mPos), curTag, "coilB");
      check(int'(bridgeOn), int'(resetN && !enableN && sleepN && !mFault), curTag, "bridgeOn");
      check(int'(faultN), int'(!mFault), curTag, "faultN");
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      stepIn = 1'b1; waitCyc(3);
      stepIn = 1'b0; waitCyc(3);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    waitCyc(3);
    curTag = "R1";
    check(int'(bridgeOn), 0, "R1", "bridgeOn in reset");
    check(int'(coilA), 90, "R1", "coilA home");
    check(int'(coilB), 90, "R1", "coilB home");
    running = 1'b1;
    resetN = 1'b1;
    enableN = 1'b0;
    waitCyc(WAKE + 4);
    check(int'(bridgeOn), 1, "R7", "bridgeOn enabled");

    curTag = "R6"; modeSel = 3'd0; dirIn = 1'b1;
    pulse(3);
    check(int'(coilA), 90, "R6", "coilA at 315");
    check(int'(coilB), -90, "R6", "coilB at 315");

    curTag = "R2"; modeSel = 3'd5;
    pulse(15);
    check(int'(coilA), 127, "R2", "coilA at p127");
    check(int'(coilB), -6, "R2", "coilB at p127");

    curTag = "R4";
    pulse(1);
    check(int'(coilB), 0, "R4", "coilB after wrap up");
    dirIn = 1'b0;
    pulse(2);

    curTag = "R3"; dirIn = 1'b1; modeSel = 3'd7;
    pulse(130);
    stepIn = 1'b1; waitCyc(12); stepIn = 1'b0; waitCyc(4);

    curTag = "R5";
    for (int m = 1; m <= 4; m++) begin
      modeSel = 3'(m);
      dirIn = 1'b1; pulse(5);
      dirIn = 1'b0; pulse(3);
    end
    modeSel = 3'd6; pulse(2);

    curTag = "R6"; modeSel = 3'd5; dirIn = 1'b1;
    pulse(3);
    modeSel = 3'd0; dirIn = 1'b0; pulse(2);
    dirIn = 1'b1; pulse(1);
    modeSel = 3'd5; pulse(5);
    modeSel = 3'd0; pulse(3);

    curTag = "R7"; modeSel = 3'd5;
    enableN = 1'b1; waitCyc(1);
    check(int'(bridgeOn), 0, "R7", "bridgeOn disabled");
    pulse(3);
    enableN = 1'b0; waitCyc(2);

    curTag = "R8"; sleepN = 1'b0;
    pulse(2);
    ocpIn = 1'b1; waitCyc(20); ocpIn = 1'b0;
    check(int'(faultN), 1, "R8", "faultN after ocp in sleep");

    curTag = "R9"; sleepN = 1'b1;
    pulse(2);
    waitCyc(WAKE);
    pulse(2);

    curTag = "R10";
    ocpIn = 1'b1; waitCyc(OCP); ocpIn = 1'b0; waitCyc(3);
    check(int'(faultN), 1, "R10", "faultN after short burst");
    ocpIn = 1'b1; waitCyc(OCP + 4); ocpIn = 1'b0; waitCyc(2);
    check(int'(faultN), 0, "R10", "faultN after long burst");
    pulse(2);

    curTag = "R11";
    enableN = 1'b1; waitCyc(3); enableN = 1'b0;
    sleepN = 1'b0; waitCyc(3); sleepN = 1'b1; waitCyc(3);
    check(int'(faultN), 0, "R11", "faultN held");
    resetN = 1'b0; waitCyc(2);
    check(int'(faultN), 1, "R11", "faultN cleared by reset");
    check(int'(coilA), 90, "R1", "coilA home after reset");
    resetN = 1'b1;
    curTag = "R9";
    pulse(2);
    waitCyc(WAKE);
    curTag = "R1";
    pulse(1);
    waitCyc(4);
    finishRun();
  end
endmodule